// File: doc/BRIEF.md
# Receive Frame Filter with Outcome Counters

This block sits on the receive path between a byte-wide Ethernet receive stream and the packet buffer that stores frames. Every incoming frame, trailing 4-byte frame check sequence included, is tracked as it arrives. The block keeps a running reflected CRC-32 and a byte count. It also records whether the downstream buffer reported itself full on the frame's first byte.

When the last byte arrives, the frame gets exactly one outcome. The outcome is either forwarded or one of four discard reasons, tested in a fixed priority order. A frame flagged full on its first byte puts no bytes on the output at all. Any other frame is passed on one cycle late, byte by byte, and ends with a commit or an abort pulse on the cycle of its last byte. The downstream buffer keeps bytes only from a committed frame and rolls the rest back.

Each outcome has its own saturating counter. Software reads a counter by presenting its select code on a small read port. A single write-only clear strobe zeroes all five counters at once.

Top module: `rxf_filter`

## Requirements
- R1: A frame not flagged full appears on the output in order, each byte one cycle after it is taken in (gaps in `in_valid` are allowed). The last byte carries either `out_commit` or `out_abort`, never both.
- R2: If `buf_full` is high on a frame's first byte, the frame produces no output byte, no commit and no abort, and the full counter (select 1) counts it. The level of `buf_full` on later bytes has no effect.
- R3: A frame with fewer than 60 bytes before the 4 check bytes (fewer than 64 in total) is aborted and counted under select 2. Exactly 60 passes this test.
- R4: A frame with more than 1514 bytes before the check bytes (more than 1518 in total) is aborted and counted under select 3. Exactly 1514 passes this test.
- R5: A frame whose CRC check fails is aborted and counted under select 4. The CRC is reflected polynomial 0xEDB88320 with start value 0xFFFFFFFF, run over every byte including the check bytes. A good frame leaves register value 0xDEBB20E3, which is the bit-reversed form of 0xC704DD7B. The check bytes are the complement of the payload CRC, sent low byte first.
- R6: A frame that passes every test is committed and counted under select 0.
- R7: Each frame increments exactly one counter, chosen by priority: full, then too small, then too big, then CRC failure.
- R8: A one-cycle `cnt_clear` zeroes all counters on the next edge. A clear in the same cycle as a frame's last byte wins over that frame's increment.
- R9: Counters are CNT_W bits (32 by default) and hold at their all-ones value instead of wrapping.
- R10: `cnt_rdata` returns the counter named by `cnt_sel` (0 forwarded, 1 full, 2 too small, 3 too big, 4 CRC fail) and reads 0 for select codes 5 to 7.
- R11: During and right after reset, `out_valid`, `out_commit` and `out_abort` are low and every counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the frame's final byte |
| buf_full | input | 1 | Downstream buffer has no room (sampled on first byte) |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_commit | output | 1 | Final byte of a frame to keep |
| out_abort | output | 1 | Final byte of a frame to roll back |
| cnt_sel | input | 3 | Counter select code |
| cnt_clear | input | 1 | Write strobe that zeroes all counters |
| cnt_rdata | output | CNT_W | Selected counter value |

## Verification
The assertions rely on a few input rules. `in_last` is raised only together with `in_valid`. `cnt_clear` is a single-cycle strobe. The only inputs the counters respond to are a frame end and the clear strobe. Under these rules, at most one counter may move in any cycle, and that counter moves by one. The stimulus follows the rules: it drives whole frames one byte per cycle, with at most one idle gap and the last flag on the final byte only. It raises the clear strobe for one cycle, either between frames or deliberately on a last byte. It returns all inputs to idle before the next scenario.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int SEL_W = 3;
  localparam int NKIND = 5;

  typedef enum logic [SEL_W-1:0] {
    KIND_FWD   = 3'd0,
    KIND_FULL  = 3'd1,
    KIND_SMALL = 3'd2,
    KIND_BIG   = 3'd3,
    KIND_CRC   = 3'd4
  } rxf_kind_e;

  localparam logic [31:0] CRC_POLY    = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

  // One byte through the reflected CRC register, LSB first.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/rxf_crc32.sv
module rxf_crc32 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       start,
  input  logic [7:0] data,
  output logic       ok_now
);
  import rxf_pkg::*;

  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d  = crc_step(start ? CRC_INIT : crc_q, data);
    ok_now = (crc_d == CRC_RESIDUE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= CRC_INIT;
    else if (en) crc_q <= crc_d;
  end
endmodule

// File: rtl/rxf_stat_bank.sv
module rxf_stat_bank #(
  parameter int CNT_W = 32,
  parameter int NCNT  = rxf_pkg::NKIND
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       inc_en,
  input  logic [rxf_pkg::SEL_W-1:0]  inc_sel,
  input  logic [rxf_pkg::SEL_W-1:0]  rd_sel,
  output logic [CNT_W-1:0]           rd_data,
  output logic [NCNT*CNT_W-1:0]      cnt_flat
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q [NCNT];

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    logic             hit;
    logic             upd;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
      hit   = inc_en && (inc_sel == rxf_pkg::SEL_W'(g));
      upd   = clear || (hit && (cnt_q[g] != CMAX));
      cnt_d = clear ? '0 : cnt_q[g] + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q[g] <= '0;
      else if (upd) cnt_q[g] <= cnt_d;
    end

    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCNT; i++) begin
      if (rd_sel == rxf_pkg::SEL_W'(i)) rd_data = cnt_q[i];
    end
  end
endmodule

// File: rtl/rxf_filter.sv
module rxf_filter #(
  parameter int CNT_W   = 32,
  parameter int MIN_LEN = 60,
  parameter int MAX_LEN = 1514,
  parameter int FCS_LEN = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [7:0]                in_data,
  input  logic                      in_last,
  input  logic                      buf_full,
  output logic                      out_valid,
  output logic [7:0]                out_data,
  output logic                      out_commit,
  output logic                      out_abort,
  input  logic [rxf_pkg::SEL_W-1:0] cnt_sel,
  input  logic                      cnt_clear,
  output logic [CNT_W-1:0]          cnt_rdata
);
  import rxf_pkg::*;

  localparam int              LEN_W   = $clog2(MAX_LEN + FCS_LEN + 2);
  localparam logic [LEN_W-1:0] MIN_TOT = LEN_W'(MIN_LEN + FCS_LEN);
  localparam logic [LEN_W-1:0] MAX_TOT = LEN_W'(MAX_LEN + FCS_LEN);

  logic             in_frame_q, in_frame_d;
  logic             full_q, full_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             first, full_now, end_now, crc_ok;
  logic [LEN_W-1:0] len_base, len_now;
  rxf_kind_e        kind;

  logic       ov_q, ov_d, cm_q, cm_d, ab_q, ab_d;
  logic [7:0] od_q;

  logic [NKIND*CNT_W-1:0] cnt_flat;

  rxf_crc32 u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (in_valid),
    .start  (first),
    .data   (in_data),
    .ok_now (crc_ok)
  );

  // Frame tracking and classification
  always_comb begin
    first    = in_valid && !in_frame_q;
    full_now = first ? buf_full : full_q;
    end_now  = in_valid && in_last;
    len_base = first ? '0 : len_q;
    len_now  = (len_base == '1) ? len_base : len_base + 1'b1;

    if (full_now)               kind = KIND_FULL;
    else if (len_now < MIN_TOT) kind = KIND_SMALL;
    else if (len_now > MAX_TOT) kind = KIND_BIG;
    else if (!crc_ok)           kind = KIND_CRC;
    else                        kind = KIND_FWD;

    in_frame_d = in_valid ? !in_last : in_frame_q;
    full_d     = in_valid ? full_now : full_q;
    len_d      = in_valid ? len_now  : len_q;

    ov_d = in_valid && !full_now;
    cm_d = end_now && !full_now && (kind == KIND_FWD);
    ab_d = end_now && !full_now && (kind != KIND_FWD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      full_q     <= 1'b0;
      len_q      <= '0;
      ov_q       <= 1'b0;
      cm_q       <= 1'b0;
      ab_q       <= 1'b0;
    end else begin
      in_frame_q <= in_frame_d;
      full_q     <= full_d;
      len_q      <= len_d;
      ov_q       <= ov_d;
      cm_q       <= cm_d;
      ab_q       <= ab_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        od_q <= '0;
    else if (in_valid) od_q <= in_data;
  end

  assign out_valid  = ov_q;
  assign out_data   = od_q;
  assign out_commit = cm_q;
  assign out_abort  = ab_q;

  rxf_stat_bank #(.CNT_W(CNT_W), .NCNT(NKIND)) u_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_clear),
    .inc_en   (end_now),
    .inc_sel  (kind),
    .rd_sel   (cnt_sel),
    .rd_data  (cnt_rdata),
    .cnt_flat (cnt_flat)
  );
endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk #(
  parameter int CNT_W = 32,
  parameter int NCNT  = rxf_pkg::NKIND
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  out_valid,
  input logic                  out_commit,
  input logic                  out_abort,
  input logic                  cnt_clear,
  input logic [NCNT*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [NCNT*CNT_W-1:0] prev_q;
  logic                  clr_q;
  logic [NCNT-1:0]       chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      prev_q <= cnt_flat;
      clr_q  <= cnt_clear;
    end
  end

  a_r1_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_commit && out_abort));

  a_r1_end_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (out_commit || out_abort) |-> out_valid);

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (cnt_flat == '0));

  a_r6_commit_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (out_commit && !clr_q && (prev_q[0 +: CNT_W] != CMAX))
      |-> (cnt_flat[0 +: CNT_W] == prev_q[0 +: CNT_W] + 1'b1));

  for (genvar g = 0; g < NCNT; g++) begin : g_c
    assign chg[g] = (cnt_flat[g*CNT_W +: CNT_W] != prev_q[g*CNT_W +: CNT_W]);

    a_r9_saturate_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_flat[g*CNT_W +: CNT_W] == CMAX) && !cnt_clear)
        |=> (cnt_flat[g*CNT_W +: CNT_W] == CMAX));

    a_r7_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_q |-> (!chg[g] ||
        (cnt_flat[g*CNT_W +: CNT_W] == prev_q[g*CNT_W +: CNT_W] + 1'b1)));
  end

  a_r7_single_counter: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_q |-> ($countones(chg) <= 1));
endmodule

bind rxf_filter rxf_filter_chk #(.CNT_W(CNT_W), .NCNT(rxf_pkg::NKIND)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .out_valid  (out_valid),
  .out_commit (out_commit),
  .out_abort  (out_abort),
  .cnt_clear  (cnt_clear),
  .cnt_flat   (cnt_flat)
);

// File: tb/rxf_filter_tb.sv
`timescale 1ns/1ps
module rxf_filter_tb;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_last, buf_full, cnt_clear;
  logic [7:0]    in_data;
  logic [2:0]    cnt_sel;
  logic          out_valid, out_commit, out_abort;
  logic [7:0]    out_data;
  logic [CW-1:0] cnt_rdata;

  int n_chk = 0, n_fail = 0;
  int exp_cnt [5];
  logic [7:0] frm [2048];
  int mon_n = 0, mon_err = 0, mon_cm = 0, mon_ab = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rxf_filter #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .buf_full(buf_full), .out_valid(out_valid),
    .out_data(out_data), .out_commit(out_commit), .out_abort(out_abort),
    .cnt_sel(cnt_sel), .cnt_clear(cnt_clear), .cnt_rdata(cnt_rdata)
  );

  // Output monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (out_data !== frm[mon_n]) mon_err++;
      mon_n++;
      if (out_commit) mon_cm++;
      if (out_abort)  mon_ab++;
    end
  end

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic read_cnt(input int sel, output int v);
    @(negedge clk);
    cnt_sel = 3'(sel);
    #1 v = int'(cnt_rdata);
  endtask

  task automatic check_counters(input string req);
    int v;
    for (int s = 0; s < 5; s++) begin
      read_cnt(s, v);
      chk($sformatf("%s cnt[%0d]", req, s), v, exp_cnt[s]);
    end
  endtask

  // fmode: 0 never full, 1 full on first byte, 2 full on all later bytes
  task automatic send_frame(input int plen, input bit bad, input int fmode,
                            input bit gap, input bit clr_last, input string req);
    logic [31:0] c = 32'hFFFFFFFF;
    int tot = plen + 4;
    int kind;
    bit dropped = (fmode == 1);
    for (int i = 0; i < plen; i++) begin
      frm[i] = 8'(i * 13 + plen);
      c = ref_crc(c, frm[i]);
    end
    c = ~c;
    for (int i = 0; i < 4; i++) frm[plen + i] = c[8*i +: 8];
    if (bad) frm[plen] = frm[plen] ^ 8'h01;
    if (dropped)          kind = 1;
    else if (plen < 60)   kind = 2;
    else if (plen > 1514) kind = 3;
    else if (bad)         kind = 4;
    else                  kind = 0;
    mon_n = 0; mon_err = 0; mon_cm = 0; mon_ab = 0;
    for (int i = 0; i < tot; i++) begin
      @(negedge clk);
      if (gap && i == 10) begin
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);
      end
      in_valid  = 1'b1;
      in_data   = frm[i];
      in_last   = (i == tot - 1);
      buf_full  = (fmode == 1) ? (i == 0) : (fmode == 2) ? (i != 0) : 1'b0;
      cnt_clear = clr_last && (i == tot - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; buf_full = 1'b0; cnt_clear = 1'b0;
    repeat (2) @(negedge clk);
    if (clr_last) for (int s = 0; s < 5; s++) exp_cnt[s] = 0;
    else if (exp_cnt[kind] < CMAX) exp_cnt[kind]++;
    chk({req, " bytes out"}, mon_n, dropped ? 0 : tot);
    chk({req, " byte mismatches"}, mon_err, 0);
    chk({req, " commit"}, mon_cm, (!dropped && kind == 0) ? 1 : 0);
    chk({req, " abort"}, mon_ab, (!dropped && kind != 0) ? 1 : 0);
    check_counters(req);
  endtask

  task automatic do_clear;
    @(negedge clk); cnt_clear = 1'b1;
    @(negedge clk); cnt_clear = 1'b0;
    for (int s = 0; s < 5; s++) exp_cnt[s] = 0;
  endtask

  task automatic t_reset;
    int v;
    chk("R11 out_valid", int'(out_valid), 0);
    chk("R11 out_commit", int'(out_commit), 0);
    chk("R11 out_abort", int'(out_abort), 0);
    check_counters("R11 reset");
  endtask

  task automatic t_good;
    send_frame(60, 0, 0, 0, 0, "R6 R3 min-length good");
    send_frame(200, 0, 0, 1, 0, "R1 good with gap");
    send_frame(1514, 0, 0, 0, 0, "R4 max-length good");
    send_frame(100, 0, 2, 0, 0, "R2 full after first byte ignored");
  endtask

  task automatic t_discards;
    send_frame(59, 0, 0, 0, 0, "R3 too small");
    send_frame(1515, 0, 0, 0, 0, "R4 too big");
    send_frame(100, 1, 0, 0, 0, "R5 crc fail");
    send_frame(80, 0, 1, 0, 0, "R2 full first byte");
  endtask

  task automatic t_priority;
    send_frame(20, 1, 1, 0, 0, "R7 full over small+crc");
    send_frame(10, 1, 0, 0, 0, "R7 small over crc");
    send_frame(1600, 1, 0, 0, 0, "R7 big over crc");
    send_frame(1, 0, 0, 0, 0, "R7 tiny frame");
  endtask

  task automatic t_clear;
    do_clear();
    check_counters("R8 clear");
    send_frame(70, 0, 0, 0, 0, "R8 count after clear");
    send_frame(70, 0, 0, 0, 1, "R8 clear beats increment");
  endtask

  task automatic t_sat;
    do_clear();
    for (int n = 0; n < CMAX + 2; n++) send_frame(5, 0, 0, 0, 0, "R9 saturate");
  endtask

  task automatic t_sel;
    int v;
    for (int s = 5; s < 8; s++) begin
      read_cnt(s, v);
      chk($sformatf("R10 unused select %0d", s), v, 0);
    end
  endtask

  task automatic finish_sim;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    buf_full = 1'b0; cnt_clear = 1'b0; cnt_sel = '0;
    for (int s = 0; s < 5; s++) exp_cnt[s] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_discards();
    t_priority();
    t_sel();
    t_clear();
    t_sat();
    done = 1;
    finish_sim();
  end
endmodule